// File: doc/BRIEF.md
# Dual-Channel Subsampled IF Digital Downconverter

This block takes real samples from two analog-to-digital converters that subsample an intermediate frequency. After undersampling, the wanted signal sits at a residual digital frequency: 140 MHz sampled at 122.88 MHz leaves 17.12 MHz. The block mixes both sample streams down to complex baseband. One phase-accumulator oscillator is tuned to that alias frequency and produces a quadrature cosine/sine pair. Each channel multiplies its real sample by the cosine to form I and by the negated sine to form Q. The results are rounded and clamped to the output width.

The two channels share the oscillator, so they stay phase-coherent. The pair can carry two independent single-antenna streams or the two branches of one multi-antenna stream. The oscillator advances only when a sample is marked valid. A synchronous reset returns the phase to zero for both channels at once. The tuning word sits in a register. Reset loads it with the value for the 17.12 MHz alias, and a write strobe can replace it. Decimation filtering and symbol timing belong to the blocks that follow.

Top module: `ddc_dual`

## Requirements
- R1: The 32-bit phase accumulator adds the current tuning word once for each cycle with `in_valid` high. In a cycle with `in_valid` low the phase stays unchanged.
- R2: Reset loads the tuning word with 598387371, which is round(17.12/122.88 × 2^32). A cycle with `tune_wr` high loads `tune_word`. When a load falls in the same cycle as a valid sample, that sample's phase step uses the old word, and the new word applies from the next valid sample onward.
- R3: The upper 12 phase bits form an index k. The oscillator gives sine = round(131071·sin(2πk/4096)) and cosine = round(131071·cos(2πk/4096)), both rounded to nearest with ties away from zero. Each sample is mixed with the values for the phase held before that sample's own step.
- R4: For a 14-bit signed sample x, I = floor((x·cos + 8192) / 16384) and Q = floor((−x·sin + 8192) / 16384). Both are clamped to the signed 18-bit range.
- R5: `out_valid` goes high exactly two clock cycles after a cycle with `in_valid` high and is low otherwise. I and Q change only with a valid result and hold their values in between.
- R6: Both channels use the same oscillator phase in every cycle. Equal samples on the two channels give equal I and Q.
- R7: A synchronous `rst` sets the phase to zero, I and Q to zero, `out_valid` low and the tuning word to its reset value. The first valid sample after reset is mixed at phase zero.
- R8: A full-scale-limited tone at the alias frequency, sampled from phase zero, gives an average I over 768 samples within 1% of A·131071/32768 and an average Q within that same margin of zero, where A is the tone amplitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Both channel samples are valid this cycle |
| adc_in | input | 2×14 | Signed samples, element 0 for channel 0, element 1 for channel 1 |
| tune_wr | input | 1 | Load strobe for the tuning word |
| tune_word | input | 32 | New phase increment per valid sample |
| out_valid | output | 1 | I/Q outputs carry a new result |
| i_out | output | 2×18 | Signed in-phase result per channel |
| q_out | output | 2×18 | Signed quadrature result per channel |

## Verification
A tuning-word load can fall in the same cycle as a valid sample, which both steps the phase and is mixed. The bench provokes this by writing a new word together with a valid sample. It checks against a model in which that step still uses the old increment, with every later output compared exactly. The same collision is repeated after gapped traffic, and a reset is also issued in the middle of a stream, so the phase-hold and restart rules meet the load rule on nearby cycles.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int ADC_W   = 14;
    localparam int NCO_W   = 18;
    localparam int OUT_W   = 18;
    localparam int PHASE_W = 32;
    localparam int LUT_AW  = 12;
    localparam int NCH     = 2;

    localparam int PROD_W  = ADC_W + NCO_W;
    localparam int SHIFT   = PROD_W - OUT_W;
    localparam int QTR     = 1 << (LUT_AW - 2);
    localparam int AMP     = (1 << (NCO_W - 1)) - 1;
    localparam int OUT_MAX = (1 << (OUT_W - 1)) - 1;
    localparam int OUT_MIN = -(1 << (OUT_W - 1));

    localparam logic [PHASE_W-1:0] TUNE_DEFAULT = 32'd598387371;

    typedef logic signed [ADC_W-1:0]  adc_t;
    typedef logic signed [NCO_W-1:0]  nco_t;
    typedef logic signed [OUT_W-1:0]  out_t;
    typedef logic signed [PROD_W:0]   prod_t;
    typedef logic [PHASE_W-1:0]       phase_t;
    typedef logic [LUT_AW-1:0]        lut_idx_t;

    typedef struct packed {
        nco_t cos_v;
        nco_t sin_v;
    } osc_pair_t;

    typedef struct packed {
        out_t i;
        out_t q;
    } bb_t;

    typedef struct packed {
        logic                         vld;
        logic [NCH-1:0][ADC_W-1:0]    x;
    } stage_t;

    // One quarter-wave entry: amplitude-scaled sine, nearest, ties away from zero
    function automatic nco_t quarter_val(input int k);
        real ang;
        real r;
        int  v;
        ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(4 * QTR);
        r   = real'(AMP) * $sin(ang);
        v   = (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
        return nco_t'(v);
    endfunction

    // Round half up at the dropped LSBs, then clamp to the output range
    function automatic out_t round_sat(input prod_t p);
        prod_t t;
        prod_t s;
        t = p + (prod_t'(1) <<< (SHIFT - 1));
        s = t >>> SHIFT;
        if (s > prod_t'(OUT_MAX))
            return out_t'(OUT_MAX);
        else if (s < prod_t'(OUT_MIN))
            return out_t'(OUT_MIN);
        else
            return out_t'(s);
    endfunction

endpackage

// File: rtl/ddc_sincos_lut.sv
module ddc_sincos_lut
    import ddc_pkg::*;
(
    input  lut_idx_t  idx,
    output osc_pair_t osc
);

    localparam int OFF_W = LUT_AW - 2;

    // Quarter table, one extra entry so the mirrored address reaches the peak
    nco_t qtab [0:QTR];

    for (genvar g = 0; g <= QTR; g++) begin : g_tab
        assign qtab[g] = quarter_val(g);
    end

    // Port 0 reads sine at idx, port 1 reads sine a quarter turn later (cosine)
    lut_idx_t addr [2];
    nco_t     val  [2];

    assign addr[0] = idx;
    assign addr[1] = idx + lut_idx_t'(QTR);

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [1:0]       quad;
        logic [OFF_W-1:0] off;
        logic [OFF_W:0]   tidx;
        nco_t             mag;

        assign quad = addr[p][LUT_AW-1 -: 2];
        assign off  = addr[p][OFF_W-1:0];
        // Odd quadrants read the table backwards from the peak
        assign tidx = quad[0] ? ((OFF_W+1)'(QTR) - {1'b0, off}) : {1'b0, off};
        assign mag  = qtab[tidx];
        // Lower half-turn is positive, upper half-turn negative
        assign val[p] = quad[1] ? -mag : mag;
    end

    assign osc.sin_v = val[0];
    assign osc.cos_v = val[1];

endmodule

// File: rtl/ddc_nco.sv
module ddc_nco
    import ddc_pkg::*;
#(
    parameter phase_t TUNE_RESET = TUNE_DEFAULT
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  logic      tune_wr,
    input  phase_t    tune_word,
    output osc_pair_t osc_q
);

    phase_t    phase_q;
    phase_t    tune_q;
    osc_pair_t osc_c;

    ddc_sincos_lut u_lut (
        .idx (phase_q[PHASE_W-1 -: LUT_AW]),
        .osc (osc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            tune_q  <= TUNE_RESET;
            osc_q   <= '0;
        end else begin
            if (adv)
                phase_q <= phase_q + tune_q;
            if (tune_wr)
                tune_q <= tune_word;
            osc_q <= osc_c;
        end
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(phase_q)) else $error("phase moved without a sample"); // R1

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        adv |=> (phase_q == $past(phase_q) + $past(tune_q))) else $error("phase step wrong"); // R2

    AST_TUNE_LOAD: assert property (@(posedge clk) disable iff (rst)
        tune_wr |=> (tune_q == $past(tune_word))) else $error("tuning word not loaded"); // R2

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (phase_q == '0 && tune_q == TUNE_RESET)) else $error("reset state wrong"); // R7

endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer
    import ddc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      vld,
    input  adc_t      x,
    input  osc_pair_t osc,
    output bb_t       bb_q
);

    prod_t p_i;
    prod_t p_q;

    always_comb begin
        p_i = prod_t'(x) * prod_t'(osc.cos_v);
        p_q = -(prod_t'(x) * prod_t'(osc.sin_v));
    end

    always_ff @(posedge clk) begin
        if (rst)
            bb_q <= '0;
        else if (vld)
            bb_q <= '{i: round_sat(p_i), q: round_sat(p_q)};
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(bb_q)) else $error("output moved without a sample"); // R5

endmodule

// File: rtl/ddc_dual.sv
module ddc_dual
    import ddc_pkg::*;
#(
    parameter phase_t TUNE_RESET = TUNE_DEFAULT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [NCH-1:0][ADC_W-1:0]     adc_in,
    input  logic                          tune_wr,
    input  logic [PHASE_W-1:0]            tune_word,
    output logic                          out_valid,
    output logic [NCH-1:0][OUT_W-1:0]     i_out,
    output logic [NCH-1:0][OUT_W-1:0]     q_out
);

    osc_pair_t osc_q;
    stage_t    s1_q;
    logic      ov_q;
    bb_t       bb [NCH];

    // One shared oscillator keeps every channel on the same phase
    ddc_nco #(.TUNE_RESET(TUNE_RESET)) u_nco (
        .clk       (clk),
        .rst       (rst),
        .adv       (in_valid),
        .tune_wr   (tune_wr),
        .tune_word (tune_word),
        .osc_q     (osc_q)
    );

    // Samples wait one cycle to meet the registered oscillator output
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            ov_q <= 1'b0;
        end else begin
            s1_q <= '{vld: in_valid, x: adc_in};
            ov_q <= s1_q.vld;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ddc_mixer u_mix (
            .clk  (clk),
            .rst  (rst),
            .vld  (s1_q.vld),
            .x    (adc_t'(s1_q.x[c])),
            .osc  (osc_q),
            .bb_q (bb[c])
        );
        assign i_out[c] = bb[c].i;
        assign q_out[c] = bb[c].q;
    end

    assign out_valid = ov_q;

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid) else $error("valid result missing"); // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid) else $error("result without a sample"); // R5

    AST_COHERENT: assert property (@(posedge clk) disable iff (rst)
        (s1_q.vld && s1_q.x[0] == s1_q.x[1]) |=> (i_out[0] == i_out[1] && q_out[0] == q_out[1]))
        else $error("channels not coherent"); // R6

endmodule

// File: tb/ddc_dual_tb.sv
module ddc_dual_tb;
    import ddc_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      in_valid = 1'b0;
    logic [NCH-1:0][ADC_W-1:0] adc_in = '0;
    logic                      tune_wr = 1'b0;
    logic [PHASE_W-1:0]        tune_word = '0;
    logic                      out_valid;
    logic [NCH-1:0][OUT_W-1:0] i_out;
    logic [NCH-1:0][OUT_W-1:0] q_out;

    always #2 clk = ~clk;

    ddc_dual u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .adc_in    (adc_in),
        .tune_wr   (tune_wr),
        .tune_word (tune_word),
        .out_valid (out_valid),
        .i_out     (i_out),
        .q_out     (q_out)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    logic [31:0] m_phase;
    logic [31:0] m_tw;
    int hold_i [2];
    int hold_q [2];
    bit e0v, e1v;
    int e0i [2], e1i [2], e0q [2], e1q [2];
    string e0t, e1t;

    bit    eq_chk = 0;
    bit    acc_on = 0;
    int    acc_n  = 0;
    real   acc_i  = 0.0;
    real   acc_q  = 0.0;

    task automatic check(string tag, int act, int expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int rnd(real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
    endfunction

    function automatic int osc_val(int k, bit want_cos);
        real ang;
        ang = 2.0 * 3.14159265358979323846 * real'(k) / 4096.0;
        return rnd(131071.0 * (want_cos ? $cos(ang) : $sin(ang)));
    endfunction

    function automatic int rsat(longint p);
        longint s;
        s = (p + 64'sd8192) >>> 14;
        if (s > 131071) s = 131071;
        if (s < -131072) s = -131072;
        return int'(s);
    endfunction

    task automatic model_reset();
        m_phase = '0;
        m_tw    = 32'd598387371;
        for (int c = 0; c < 2; c++) begin
            hold_i[c] = 0; hold_q[c] = 0;
            e0i[c] = 0; e1i[c] = 0; e0q[c] = 0; e1q[c] = 0;
        end
        e0v = 0; e1v = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; tune_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R7: reset state at the ports
        check("R7 out_valid after reset", int'(out_valid), 0);
        for (int c = 0; c < 2; c++) begin
            check("R7 i_out after reset", int'($signed(i_out[c])), 0);
            check("R7 q_out after reset", int'($signed(q_out[c])), 0);
        end
    endtask

    task automatic step(string tag, bit v, int x0, int x1, bit wr, logic [31:0] w);
        int k;
        int xs [2];
        @(negedge clk);
        check({tag, " out_valid"}, int'(out_valid), int'(e1v));
        for (int c = 0; c < 2; c++) begin
            check({tag, " I"}, int'($signed(i_out[c])), e1i[c]);
            check({tag, " Q"}, int'($signed(q_out[c])), e1q[c]);
        end
        if (eq_chk && out_valid) begin
            check("R6 I equal", int'($signed(i_out[1])), int'($signed(i_out[0])));
            check("R6 Q equal", int'($signed(q_out[1])), int'($signed(q_out[0])));
        end
        if (acc_on && out_valid) begin
            acc_n++;
            acc_i += real'(int'($signed(i_out[0])));
            acc_q += real'(int'($signed(q_out[0])));
        end
        e1v = e0v; e1i = e0i; e1q = e0q;
        xs[0] = x0; xs[1] = x1;
        if (v) begin
            k = int'(m_phase[31:20]);
            for (int c = 0; c < 2; c++) begin
                hold_i[c] = rsat(longint'(xs[c]) * longint'(osc_val(k, 1'b1)));
                hold_q[c] = rsat(-(longint'(xs[c]) * longint'(osc_val(k, 1'b0))));
            end
            m_phase = m_phase + m_tw;
        end
        if (wr) m_tw = w;
        e0v = v; e0i = hold_i; e0q = hold_q;
        in_valid  = v;
        adc_in[0] = x0[13:0];
        adc_in[1] = x1[13:0];
        tune_wr   = wr;
        tune_word = w;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 0, 0, 1'b0, 32'd0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        real a_i, a_q, want;
        model_reset();
        do_reset();

        // R2: reset tuning word drives the phase progression
        for (int n = 0; n < 60; n++) step("R2 default word", 1'b1, 5000, -3000, 1'b0, 32'd0);
        idle("R2", 2);

        // R3: one table step per sample, every index, extreme samples
        do_reset();
        step("R3", 1'b0, 0, 0, 1'b1, 32'h0010_0000);
        for (int n = 0; n < 4096; n++) step("R3 sweep", 1'b1, 8191, -8192, 1'b0, 32'd0);
        // R4: varied samples over all indices
        for (int n = 0; n < 4096; n++)
            step("R4 products", 1'b1, ((n * 37) % 16384) - 8192, 8191 - ((n * 53) % 16384), 1'b0, 32'd0);
        idle("R4", 2);

        // R1: gapped samples hold the phase
        for (int n = 0; n < 300; n++)
            step("R1 gaps", (n % 3) != 0, 4000 - n, n * 11 - 2000, 1'b0, 32'd0);
        idle("R1", 2);

        // R5: isolated pulses, results appear two cycles later and hold
        for (int n = 0; n < 10; n++) begin
            step("R5 pulse", 1'b1, 1234 * n - 6000, 7000 - 999 * n, 1'b0, 32'd0);
            idle("R5 idle", n % 4 + 1);
        end

        // R2: load coincides with a valid sample
        step("R2 collide", 1'b1, 3000, 3000, 1'b1, 32'h0040_0000);
        for (int n = 0; n < 30; n++) step("R2 after load", 1'b1, 3000 - n * 100, -2500, 1'b0, 32'd0);
        step("R2 collide gap", 1'b1, -4000, 2222, 1'b1, 32'h0123_4567);
        step("R2 collide gap", 1'b0, 0, 0, 1'b0, 32'd0);
        for (int n = 0; n < 30; n++) step("R2 after load", (n % 2) == 0, 6000, -n * 50, 1'b0, 32'd0);

        // R7: reset mid-stream restarts at phase zero with the reset word
        for (int n = 0; n < 5; n++) step("R7 pre", 1'b1, 1000, 1000, 1'b0, 32'd0);
        do_reset();
        for (int n = 0; n < 40; n++) step("R7 restart", 1'b1, 7777, -7777, 1'b0, 32'd0);
        idle("R7", 2);

        // R6 and R8: alias tone on both channels from phase zero
        do_reset();
        eq_chk = 1;
        acc_on = 1;
        for (int n = 0; n < 768; n++) begin
            int x;
            x = rnd(6000.0 * $cos(2.0 * 3.14159265358979323846 * 107.0 * real'(n) / 768.0));
            step("R8 tone", 1'b1, x, x, 1'b0, 32'd0);
        end
        idle("R8", 2);
        acc_on = 0;
        eq_chk = 0;
        check("R8 sample count", acc_n, 768);
        a_i  = acc_i / 768.0;
        a_q  = acc_q / 768.0;
        want = 6000.0 * 131071.0 / 32768.0;
        n_cmp++;
        if (a_i < want * 0.99 || a_i > want * 1.01) begin
            n_bad++;
            $display("FAIL R8 mean I actual=%0d expected=%0d", rnd(a_i), rnd(want));
        end
        n_cmp++;
        if (a_q < -want * 0.01 || a_q > want * 0.01) begin
            n_bad++;
            $display("FAIL R8 mean Q actual=%0d expected=0", rnd(a_q));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule